// File: doc/BRIEF.md
# I2C Target Receiver with Software Acknowledge Hold

This block receives write transfers on an I2C bus as a 7-bit addressed target. The bus lines are sampled with the fast system clock. Each line goes through a synchronizer and a majority vote before Start, Stop and clock edges are extracted. The first byte after a Start is compared with a programmable own address. Matching write addresses and the data bytes that follow are placed in a one-byte receive buffer and acknowledged. Open-drain drivers are modelled as pull-low enables, and the testbench or chip-level pad logic combines them with the other devices on the wire.

A host CPU sees the block as a set of level controls, single-cycle command pulses and status flags. It can make the block hold SCL low after every acknowledged byte, so it has time to empty the buffer. With the two hold modes, the block also stops the bus before the acknowledge bit of an address or data byte. Software then decides between ACK and NACK, and an ACK-phase flag tells it which of the two interrupt points it is servicing. A full buffer or a pending overflow makes hardware refuse further bytes.

Top module: `i2c_target_rx`

## Requirements
- R1: A Start (SDA falling while SCL is high) sets `startSeen`, clears `stopSeen`, and raises `irqFlag` only when `startIrqEn` is 1. A Stop (SDA rising while SCL is high) sets `stopSeen`, clears `startSeen`, releases SDA and returns the receiver to idle, so `startSeen` and `stopSeen` are never both 1.
- R2: The first byte after a Start is received MSB first. Its upper seven bits are compared with `ownAddr` and its last bit is R/W. On a match `rwBit` takes the R/W value. A matching address with R/W = 0 is loaded into `rxBuf` and acknowledged (SDA pulled low through the 9th clock) when `bufFull` and `overflow` are both 0.
- R3: An address whose seven bits differ from `ownAddr`, or a matching address with R/W = 1, gets a NACK, loads nothing and raises no interrupt. The rest of that transfer is ignored until the next Start.
- R4: Each data byte after an acknowledged address is loaded and acknowledged. `irqFlag` rises at the 9th falling SCL edge after an ACK and stays set until a `clrIrq` pulse. A `rdBuf` pulse clears `bufFull`.
- R5: A byte that completes while `bufFull` is 1 sets `overflow` and leaves `rxBuf` unchanged. Nothing is loaded while `overflow` is 1, and an address or byte arriving then gets a NACK outside the hold modes. Only a `clrOvf` pulse clears `overflow`.
- R6: With `stretchEn` = 1, `ckp` is cleared at the 9th falling edge after each ACK and SCL is held low until a `setCkp` pulse.
- R7: With `addrHoldEn` (matching address) or `dataHoldEn` (data byte) set, the 8th falling SCL edge sets `irqFlag`, clears `ckp` and holds SCL low. When `setCkp` ends the hold, `ackNack` is driven as the 9th bit: 0 gives ACK, 1 gives NACK.
- R8: `ackTime` is 1 from the 8th falling edge of an accepted byte up to its 9th falling edge, and 0 at other times. The ACK pull-low occurs only while `ackTime` is 1.
- R9: After a NACK, `irqFlag` is not set at the 9th falling edge and later bytes are ignored until a new Start.
- R10: After reset, `bufFull`, `overflow`, `irqFlag`, `ackTime`, `startSeen`, `stopSeen`, `rwBit`, `sclPullLow` and `sdaPullLow` are 0 and `ckp` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Level of the SCL wire |
| sdaIn | input | 1 | Level of the SDA wire |
| sclPullLow | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaPullLow | output | 1 | 1 pulls SDA low (ACK) |
| ownAddr | input | 7 | Own 7-bit target address |
| stretchEn | input | 1 | Stretch SCL after each acknowledged byte |
| addrHoldEn | input | 1 | Hold before the ACK of a matching address |
| dataHoldEn | input | 1 | Hold before the ACK of a data byte |
| startIrqEn | input | 1 | Raise the interrupt on Start |
| ackNack | input | 1 | Software acknowledge choice in hold mode, 0 = ACK |
| setCkp | input | 1 | Pulse: release the clock |
| clrIrq | input | 1 | Pulse: clear the interrupt flag |
| clrOvf | input | 1 | Pulse: clear the overflow flag |
| rdBuf | input | 1 | Pulse: buffer has been read, clear buffer-full |
| rxBuf | output | 8 | Receive buffer |
| bufFull | output | 1 | Buffer holds an unread byte |
| overflow | output | 1 | A byte arrived while the buffer was full |
| rwBit | output | 1 | R/W bit of the last matching address |
| irqFlag | output | 1 | Interrupt flag |
| ckp | output | 1 | Clock-release bit, 0 holds SCL |
| ackTime | output | 1 | Acknowledge phase in progress |
| startSeen | output | 1 | Last bus condition was a Start |
| stopSeen | output | 1 | Last bus condition was a Stop |

## Verification
The hardest situation to reach is a bus stopped by the block before the acknowledge bit. A bus model that simply runs through nine clocks would never see the hold. The bench therefore splits each byte into eight data clocks and a separate acknowledge slot. The bus model waits on the wired-AND SCL level, so in between the bench can play the CPU: it checks the hold flags, picks ACK or NACK and releases the clock. Overflow is reached by leaving the buffer unread across a byte boundary, and the bench then confirms that a later address is refused until the flag is cleared.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int BIT_CNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_HOLD, ST_ACK, ST_SKIP
  } rxState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftBit;
    logic loadByte;
    logic setRw;
    logic setIrq;
    logic clrCkp;
    logic setAckTime;
    logic clrAckTime;
    logic setStart;
    logic setStop;
  } rxStrobe_t;
endpackage

// File: rtl/i2c_rx_filt.sv
module i2c_rx_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int HALF = VOTE_TAPS / 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [VOTE_TAPS-1:0]   taps;
  logic                   vote;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      taps    <= '1;
      lineOut <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], lineIn};
      taps    <= {taps[VOTE_TAPS-2:0], syncQ[SYNC_STAGES-1]};
      lineOut <= vote;
    end
  end

  always_comb begin
    int ones;
    ones = 0;
    for (int i = 0; i < VOTE_TAPS; i++) ones += int'(taps[i]);
    vote = (ones > HALF);
  end
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3,
  parameter int BYTE_W      = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      addrHoldEn,
  input  logic      dataHoldEn,
  input  logic      stretchEn,
  input  logic      startIrqEn,
  input  logic      ackNack,
  input  logic      addrHit,
  input  logic      rwLsb,
  input  logic      roomOk,
  input  logic      ckp,
  output rxStrobe_t stb,
  output logic      sdaBit,
  output logic      sclPullLow,
  output logic      sdaPullLow
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

  logic sclF, sdaF, sclQ, sdaQ;
  logic sclRise, sclFall, startCond, stopCond;
  rxState_t st, stNext;
  logic [BIT_CNT_W-1:0] bitCnt, bitCntNext;
  logic ackDrive, ackDriveNext, isAddr, holdNow;

  i2c_rx_filt #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) uSclFilt (
    .clk(clk), .rstN(rstN), .lineIn(sclIn), .lineOut(sclF));
  i2c_rx_filt #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) uSdaFilt (
    .clk(clk), .rstN(rstN), .lineIn(sdaIn), .lineOut(sdaF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      st       <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else begin
      sclQ     <= sclF;
      sdaQ     <= sdaF;
      st       <= stNext;
      bitCnt   <= bitCntNext;
      ackDrive <= ackDriveNext;
    end
  end

  assign sclRise   = sclF & ~sclQ;
  assign sclFall   = ~sclF & sclQ;
  assign startCond = sclF & sclQ & sdaQ & ~sdaF;
  assign stopCond  = sclF & sclQ & ~sdaQ & sdaF;
  assign isAddr    = (st == ST_ADDR);
  assign holdNow   = isAddr ? addrHoldEn : dataHoldEn;
  assign sdaBit    = sdaF;

  always_comb begin
    stb          = '0;
    stNext       = st;
    bitCntNext   = bitCnt;
    ackDriveNext = ackDrive;
    if (stopCond) begin
      stb.setStop  = 1'b1;
      stNext       = ST_IDLE;
      ackDriveNext = 1'b0;
    end else if (startCond) begin
      stb.setStart = 1'b1;
      stb.setIrq   = startIrqEn;
      stNext       = ST_ADDR;
      bitCntNext   = '0;
      ackDriveNext = 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_DATA: begin
          if (sclRise && bitCnt < LAST_BIT) begin
            stb.shiftBit = 1'b1;
            bitCntNext   = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            stb.setRw = isAddr & addrHit;
            if (isAddr && (!addrHit || rwLsb)) begin
              stNext = ST_SKIP;
            end else begin
              stb.loadByte   = 1'b1;
              stb.setAckTime = 1'b1;
              if (holdNow) begin
                stb.setIrq = 1'b1;
                stb.clrCkp = 1'b1;
                stNext     = ST_HOLD;
              end else begin
                ackDriveNext = roomOk;
                stNext       = ST_ACK;
              end
            end
          end
        end
        ST_HOLD: begin
          if (ckp) begin
            ackDriveNext = ~ackNack;
            stNext       = ST_ACK;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            stb.clrAckTime = 1'b1;
            ackDriveNext   = 1'b0;
            bitCntNext     = '0;
            if (ackDrive) begin
              stb.setIrq = 1'b1;
              stb.clrCkp = stretchEn;
              stNext     = ST_DATA;
            end else begin
              stNext = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sclPullLow = ~ckp | (st == ST_HOLD);
  assign sdaPullLow = ackDrive;
endmodule

// File: rtl/i2c_rx_dp.sv
module i2c_rx_dp
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic              sdaBit,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              rdBuf,
  input  logic              clrIrq,
  input  logic              clrOvf,
  input  logic              setCkp,
  output logic              addrHit,
  output logic              rwLsb,
  output logic              roomOk,
  output logic [ADDR_W:0]   rxBuf,
  output logic              bufFull,
  output logic              overflow,
  output logic              rwBit,
  output logic              irqFlag,
  output logic              ckp,
  output logic              ackTime,
  output logic              startSeen,
  output logic              stopSeen
);
  localparam int BYTE_W = ADDR_W + 1;

  logic [BYTE_W-1:0] shiftReg;

  assign addrHit = (shiftReg[BYTE_W-1 -: ADDR_W] == ownAddr);
  assign rwLsb   = shiftReg[0];
  assign roomOk  = ~bufFull & ~overflow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxBuf     <= '0;
      bufFull   <= 1'b0;
      overflow  <= 1'b0;
      rwBit     <= 1'b0;
      irqFlag   <= 1'b0;
      ckp       <= 1'b1;
      ackTime   <= 1'b0;
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end else begin
      if (stb.shiftBit) shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
      if (stb.setRw) rwBit <= rwLsb;

      if (stb.loadByte && roomOk) begin
        rxBuf   <= shiftReg;
        bufFull <= 1'b1;
      end else if (rdBuf) begin
        bufFull <= 1'b0;
      end

      if (stb.loadByte && bufFull) overflow <= 1'b1;
      else if (clrOvf)             overflow <= 1'b0;

      if (stb.setIrq)   irqFlag <= 1'b1;
      else if (clrIrq)  irqFlag <= 1'b0;

      if (stb.clrCkp)   ckp <= 1'b0;
      else if (setCkp)  ckp <= 1'b1;

      if (stb.setAckTime) ackTime <= 1'b1;
      else if (stb.clrAckTime || stb.setStart || stb.setStop) ackTime <= 1'b0;

      if (stb.setStart) begin
        startSeen <= 1'b1;
        stopSeen  <= 1'b0;
      end else if (stb.setStop) begin
        startSeen <= 1'b0;
        stopSeen  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_target_rx.sv
module i2c_target_rx
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              stretchEn,
  input  logic              addrHoldEn,
  input  logic              dataHoldEn,
  input  logic              startIrqEn,
  input  logic              ackNack,
  input  logic              setCkp,
  input  logic              clrIrq,
  input  logic              clrOvf,
  input  logic              rdBuf,
  output logic [ADDR_W:0]   rxBuf,
  output logic              bufFull,
  output logic              overflow,
  output logic              rwBit,
  output logic              irqFlag,
  output logic              ckp,
  output logic              ackTime,
  output logic              startSeen,
  output logic              stopSeen
);
  rxStrobe_t stb;
  logic sdaBit, addrHit, rwLsb, roomOk;

  i2c_rx_ctrl #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS), .BYTE_W(ADDR_W + 1)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrHoldEn(addrHoldEn), .dataHoldEn(dataHoldEn), .stretchEn(stretchEn),
    .startIrqEn(startIrqEn), .ackNack(ackNack), .addrHit(addrHit), .rwLsb(rwLsb),
    .roomOk(roomOk), .ckp(ckp), .stb(stb), .sdaBit(sdaBit),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow));

  i2c_rx_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaBit), .ownAddr(ownAddr),
    .rdBuf(rdBuf), .clrIrq(clrIrq), .clrOvf(clrOvf), .setCkp(setCkp),
    .addrHit(addrHit), .rwLsb(rwLsb), .roomOk(roomOk), .rxBuf(rxBuf),
    .bufFull(bufFull), .overflow(overflow), .rwBit(rwBit), .irqFlag(irqFlag),
    .ckp(ckp), .ackTime(ackTime), .startSeen(startSeen), .stopSeen(stopSeen));
endmodule

// File: rtl/i2c_target_rx_chk.sv
module i2c_target_rx_chk #(
  parameter int ADDR_W = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            sdaPullLow,
  input logic            rdBuf,
  input logic [ADDR_W:0] rxBuf,
  input logic            bufFull,
  input logic            overflow,
  input logic            irqFlag,
  input logic            ckp,
  input logic            ackTime,
  input logic            startSeen,
  input logic            stopSeen
);
  // R1: Start and Stop status never both set
  a_r1_start_stop_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(startSeen && stopSeen));

  // R1: a Stop leaves SDA released
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopSeen) |-> !sdaPullLow);

  // R4: buffer-full only drops after a buffer read
  a_r4_bufclr_by_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufFull) |-> $past(rdBuf));

  // R5: an overflow keeps the old buffer contents
  a_r5_ovf_keeps_buf: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $stable(rxBuf));

  // R6 and R7: every hardware clock hold comes with an interrupt
  a_r7_hold_has_irq: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ckp) |-> irqFlag);

  // R8: the ACK pull-low only happens inside the acknowledge phase
  a_r8_drive_in_ack_phase: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullLow |-> ackTime);
endmodule

bind i2c_target_rx i2c_target_rx_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .sdaPullLow(sdaPullLow), .rdBuf(rdBuf), .rxBuf(rxBuf),
  .bufFull(bufFull), .overflow(overflow), .irqFlag(irqFlag), .ckp(ckp),
  .ackTime(ackTime), .startSeen(startSeen), .stopSeen(stopSeen));

// File: tb/sim_i2c_target_rx.sv
module sim_i2c_target_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h3A;
  localparam logic [7:0] ADDR_WR = {OWN, 1'b0};
  localparam logic [7:0] ADDR_RD = {OWN, 1'b1};

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic stretchEn = 0, addrHoldEn = 0, dataHoldEn = 0, startIrqEn = 0, ackNack = 0;
  logic setCkp = 0, clrIrq = 0, clrOvf = 0, rdBuf = 0;
  logic sclPullLow, sdaPullLow, bufFull, overflow, rwBit, irqFlag, ckp, ackTime;
  logic startSeen, stopSeen;
  logic [7:0] rxBuf;
  logic sclLine, sdaLine;
  int checks = 0, fails = 0;
  logic [7:0] expQ[$];
  logic prevBf = 1'b0;
  logic a;

  assign sclLine = mScl & ~sclPullLow;
  assign sdaLine = mSda & ~sdaPullLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_target_rx u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow), .ownAddr(OWN),
    .stretchEn(stretchEn), .addrHoldEn(addrHoldEn), .dataHoldEn(dataHoldEn),
    .startIrqEn(startIrqEn), .ackNack(ackNack), .setCkp(setCkp), .clrIrq(clrIrq),
    .clrOvf(clrOvf), .rdBuf(rdBuf), .rxBuf(rxBuf), .bufFull(bufFull),
    .overflow(overflow), .rwBit(rwBit), .irqFlag(irqFlag), .ckp(ckp),
    .ackTime(ackTime), .startSeen(startSeen), .stopSeen(stopSeen));

  task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw(input int what);
    @(negedge clk);
    case (what)
      0: clrIrq = 1;
      1: rdBuf  = 1;
      2: setCkp = 1;
      default: clrOvf = 1;
    endcase
    @(negedge clk);
    clrIrq = 0; rdBuf = 0; setCkp = 0; clrOvf = 0;
  endtask

  task automatic sclHigh();
    mScl = 1'b1;
    do @(negedge clk); while (!sclLine);
  endtask

  task automatic busStart();
    @(negedge clk) mSda = 1'b1;
    waitClk(Q);
    sclHigh();
    waitClk(Q);
    mSda = 1'b0;
    waitClk(Q);
    mScl = 1'b0;
    waitClk(Q);
  endtask

  task automatic busStop();
    @(negedge clk) mSda = 1'b0;
    waitClk(Q);
    sclHigh();
    waitClk(Q);
    mSda = 1'b1;
    waitClk(Q);
  endtask

  task automatic send8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) mSda = b[i];
      waitClk(Q);
      sclHigh();
      waitClk(Q);
      mScl = 1'b0;
      waitClk(Q);
    end
  endtask

  task automatic ackSlot(output logic ackBit);
    @(negedge clk) mSda = 1'b1;
    waitClk(Q);
    sclHigh();
    waitClk(Q/2);
    ackBit = sdaLine;
    waitClk(Q/2);
    mScl = 1'b0;
    waitClk(Q);
  endtask

  // monitor: each buffer load is compared with the next expected byte
  always @(negedge clk) begin
    if (rstN && bufFull && !prevBf) begin
      if (expQ.size() == 0) check(1'b0, "R4 unexpected load", rxBuf, 8'h00);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(rxBuf == e, "R4 buffer content", rxBuf, e);
      end
    end
    prevBf <= bufFull;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    waitClk(3);
    // R10 reset state
    check({bufFull, overflow, irqFlag, ackTime, startSeen, stopSeen, rwBit} == 7'b0,
          "R10 reset flags", {1'b0, bufFull, overflow, irqFlag, ackTime, startSeen, stopSeen, rwBit}, 8'h00);
    check(ckp == 1'b1 && !sclPullLow && !sdaPullLow, "R10 reset drive", {ckp, sclPullLow, sdaPullLow}, 8'h4);
    rstN = 1'b1;
    waitClk(5);

    // basic write
    busStart();
    check(startSeen && !stopSeen, "R1 start status", {startSeen, stopSeen}, 8'h2);
    check(!irqFlag, "R1 no start irq", irqFlag, 0);
    expQ.push_back(ADDR_WR);
    send8(ADDR_WR);
    check(sdaPullLow && ackTime, "R8 ack phase driven", {sdaPullLow, ackTime}, 8'h3);
    ackSlot(a);
    check(a == 1'b0, "R2 address ack", a, 0);
    check(rwBit == 1'b0, "R2 rw cleared", rwBit, 0);
    check(irqFlag && !ackTime, "R4 irq after ack", {irqFlag, ackTime}, 8'h2);
    sw(0); sw(1);
    check(!irqFlag && !bufFull, "R4 sw clears", {irqFlag, bufFull}, 8'h0);
    expQ.push_back(8'hA5);
    send8(8'hA5);
    ackSlot(a);
    check(a == 1'b0 && irqFlag, "R4 data ack", {a, irqFlag}, 8'h1);
    sw(0); sw(1);
    busStop();
    check(stopSeen && !startSeen && !sdaPullLow, "R1 stop status", {stopSeen, startSeen, sdaPullLow}, 8'h4);

    // rejected addresses
    busStart();
    send8(ADDR_RD);
    ackSlot(a);
    check(a == 1'b1 && rwBit == 1'b1, "R3 read address nack", {a, rwBit}, 8'h3);
    check(!irqFlag && !bufFull, "R3 no irq no load", {irqFlag, bufFull}, 8'h0);
    send8(8'h11);
    ackSlot(a);
    check(a == 1'b1 && !bufFull, "R3 data ignored", {a, bufFull}, 8'h2);
    busStart();
    send8(8'h40);
    ackSlot(a);
    check(a == 1'b1 && !irqFlag && !bufFull, "R3 mismatch nack", {a, irqFlag, bufFull}, 8'h4);
    busStop();

    // overflow
    busStart();
    expQ.push_back(ADDR_WR);
    send8(ADDR_WR); ackSlot(a);
    sw(0); sw(1);
    expQ.push_back(8'h3C);
    send8(8'h3C); ackSlot(a);
    check(a == 1'b0, "R4 data before overflow", a, 0);
    sw(0);
    send8(8'hC3); ackSlot(a);
    check(a == 1'b1 && overflow, "R5 overflow nack", {a, overflow}, 8'h3);
    check(rxBuf == 8'h3C, "R5 buffer kept", rxBuf, 8'h3C);
    check(!irqFlag, "R9 no irq after nack", irqFlag, 0);
    send8(8'h77); ackSlot(a);
    check(a == 1'b1 && rxBuf == 8'h3C, "R9 later byte ignored", rxBuf, 8'h3C);
    busStop();
    sw(1);
    busStart();
    send8(ADDR_WR); ackSlot(a);
    check(a == 1'b1 && !bufFull && overflow, "R5 nack while overflow", {a, bufFull, overflow}, 8'h5);
    busStop();
    sw(3);
    check(!overflow, "R5 overflow cleared", overflow, 0);

    // stretch after each ack
    stretchEn = 1'b1;
    busStart();
    expQ.push_back(ADDR_WR);
    send8(ADDR_WR); ackSlot(a);
    waitClk(40);
    check(sclPullLow && !ckp && irqFlag, "R6 stretch after ack", {sclPullLow, ckp, irqFlag}, 8'h5);
    sw(0); sw(1); sw(2);
    check(!sclPullLow && ckp, "R6 release", {sclPullLow, ckp}, 8'h1);
    expQ.push_back(8'h5A);
    send8(8'h5A); ackSlot(a);
    waitClk(20);
    check(a == 1'b0 && sclPullLow, "R6 stretch after data", {a, sclPullLow}, 8'h1);
    sw(0); sw(1); sw(2);
    busStop();
    stretchEn = 1'b0;

    // hold modes with software acknowledge
    addrHoldEn = 1'b1; dataHoldEn = 1'b1;
    busStart();
    expQ.push_back(ADDR_WR);
    send8(ADDR_WR);
    waitClk(20);
    check(irqFlag && !ckp && sclPullLow, "R7 address hold", {irqFlag, ckp, sclPullLow}, 8'h5);
    check(ackTime && !sdaPullLow && bufFull, "R8 pre-ack state", {ackTime, sdaPullLow, bufFull}, 8'h5);
    sw(0); sw(1);
    ackNack = 1'b0;
    sw(2);
    ackSlot(a);
    check(a == 1'b0, "R7 software ack", a, 0);
    check(irqFlag && !ackTime, "R8 post-ack irq", {irqFlag, ackTime}, 8'h2);
    sw(0);
    expQ.push_back(8'h96);
    send8(8'h96);
    waitClk(20);
    check(irqFlag && sclPullLow && ackTime, "R7 data hold", {irqFlag, sclPullLow, ackTime}, 8'h7);
    sw(0); sw(1);
    ackNack = 1'b1;
    sw(2);
    ackSlot(a);
    check(a == 1'b1, "R7 software nack", a, 1);
    check(!irqFlag && !ackTime, "R9 no irq after nack", {irqFlag, ackTime}, 8'h0);
    send8(8'h12); ackSlot(a);
    check(a == 1'b1 && !bufFull && !irqFlag, "R9 skip after nack", {a, bufFull, irqFlag}, 8'h4);
    busStop();
    addrHoldEn = 1'b0; dataHoldEn = 1'b0; ackNack = 1'b0;

    // interrupt on start
    startIrqEn = 1'b1;
    busStart();
    check(irqFlag && startSeen, "R1 start irq", {irqFlag, startSeen}, 8'h3);
    sw(0);
    busStop();
    startIrqEn = 1'b0;

    waitClk(10);
    check(expQ.size() == 0, "R4 all loads seen", 8'(expQ.size()), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule